// File: doc/BRIEF.md
# Selectable-Prescale Bit-Rate Tick Generator

This block derives the bit-rate timing for a full-duplex serial port from the system clock. An 8-bit reload value X sets the basic interval. Two inputs then pick one of three rate families, so one value of X serves three speeds:
- a coarse asynchronous rate, with one bit every 64·(X+1) clocks;
- a fine asynchronous rate, with one bit every 16·(X+1) clocks;
- a synchronous rate, with one bit every 4·(X+1) clocks.

The transmitter and the receiver share the generator. It drives a one-cycle `bit_tick` at the bit rate. In the asynchronous families it also drives `os_tick`, a strobe at sixteen times the bit rate that a receiver uses to sample its input. A write of a new reload value restarts all internal counting at once. While `enable` is low the counters are held in their start state and no ticks come out.

Internally a fixed divide-by-4 stage feeds a reloading 8-bit down-counter. The fine asynchronous family bypasses that stage. A post-divider then divides the counter's underflow pulse by 16 in the asynchronous families and passes it through unchanged in the synchronous family.

Top module: `bitrate_tick_gen`

## Requirements
- R1: With `sync_mode`=0 and `fine_speed`=0, `bit_tick` is high on exactly the clock cycles k·64·(X+1) after the restart edge (k ≥ 1), and low on every other cycle.
- R2: With `sync_mode`=0 and `fine_speed`=1, `bit_tick` is high on exactly the cycles k·16·(X+1) after the restart edge.
- R3: With `sync_mode`=1, `bit_tick` is high on exactly the cycles k·4·(X+1) after the restart edge, whatever the value of `fine_speed`.
- R4: In the asynchronous families, `os_tick` is high on exactly the cycles k·P/16 after the restart edge, where P is the bit period. Every `bit_tick` therefore falls on an `os_tick`.
- R5: With `sync_mode`=1, `os_tick` stays low.
- R6: A clock edge with `reload_we`=1 stores `reload_din` as X and is a restart edge. Both ticks are low in the following cycle. The next ticks follow the new X, counted from that edge, whatever phase the counters were in.
- R7: While `enable` is low, both ticks stay low. The last edge with `enable` low is the restart edge for the count that follows.
- R8: Synchronous active-high `rst` clears X to 0 and holds both ticks low. The last edge with `rst` high is a restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the generator; low holds it in its start state |
| sync_mode | input | 1 | 1 selects the synchronous family (divisor 4) |
| fine_speed | input | 1 | In asynchronous mode, 1 selects divisor 16 and 0 selects divisor 64 |
| reload_we | input | 1 | Write strobe for the reload value; also restarts the count |
| reload_din | input | 8 | New reload value X |
| bit_tick | output | 1 | One-cycle pulse at the bit rate |
| os_tick | output | 1 | Sixteen-times oversample strobe in the asynchronous families |

## Verification
The hardest case to reach is a reload write that lands partway through a count. It tests whether the divide-by-4 phase and the post-divider phase are both discarded, or whether one of them keeps a partial count that shifts the first new tick. The bench runs the generator with one value until all three stages are mid-phase, then writes a different value and checks every cycle against the new period counted from the write edge. The coarse family's long periods are covered by a dense sweep of small X values, plus one full period at the maximum X.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;

    localparam int unsigned RELOAD_W   = 8;
    localparam int unsigned PREDIV     = 4;
    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned PRE_W      = $clog2(PREDIV);
    localparam int unsigned POST_W     = $clog2(OVERSAMPLE);

    typedef enum logic [1:0] {
        FAM_COARSE = 2'd0,
        FAM_FINE   = 2'd1,
        FAM_SYNC   = 2'd2
    } rate_family_e;

    typedef struct packed {
        logic bypass_pre;
        logic bypass_post;
        logic oversample_on;
    } stage_cfg_t;

    function automatic rate_family_e family_of(input logic sync_sel, input logic fine_sel);
        if (sync_sel)      return FAM_SYNC;
        else if (fine_sel) return FAM_FINE;
        else               return FAM_COARSE;
    endfunction

    function automatic stage_cfg_t cfg_of(input rate_family_e fam);
        stage_cfg_t c;
        c.bypass_pre    = (fam == FAM_FINE);
        c.bypass_post   = (fam == FAM_SYNC);
        c.oversample_on = (fam != FAM_SYNC);
        return c;
    endfunction

endpackage

// File: rtl/bt_prediv.sv
module bt_prediv #(
    parameter int unsigned RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic bypass,
    output logic step
);
    localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign step = !restart && (bypass || (phase_q == LAST));
endmodule

// File: rtl/bt_reload_counter.sv
module bt_reload_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic         underflow
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (restart) begin
            count_q <= load_val;
        end else if (step) begin
            if (count_q == '0) count_q <= load_val;
            else               count_q <= count_q - 1'b1;
        end
    end

    assign underflow = step && !restart && (count_q == '0);
endmodule

// File: rtl/bt_postdiv.sv
module bt_postdiv #(
    parameter int unsigned RATIO = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic bypass,
    input  logic base_in,
    output logic div_out
);
    localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (base_in) begin
            if (phase_q == LAST) phase_q <= '0;
            else                 phase_q <= phase_q + 1'b1;
        end
    end

    assign div_out = base_in && (bypass || (phase_q == LAST));
endmodule

// File: rtl/bitrate_tick_gen.sv
module bitrate_tick_gen
    import bitrate_pkg::*;
#(
    parameter int unsigned XW       = RELOAD_W,
    parameter int unsigned PRE_DIV  = PREDIV,
    parameter int unsigned OS_RATIO = OVERSAMPLE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          sync_mode,
    input  logic          fine_speed,
    input  logic          reload_we,
    input  logic [XW-1:0] reload_din,
    output logic          bit_tick,
    output logic          os_tick
);
    logic [XW-1:0] reload_q;
    logic          restart;
    logic [XW-1:0] load_val;
    rate_family_e  fam;
    stage_cfg_t    cfg;
    logic          pre_step;
    logic          base_tick;
    logic          bit_raw;
    logic          bit_q;
    logic          os_q;

    assign restart  = !enable || reload_we;
    assign load_val = reload_we ? reload_din : reload_q;
    assign fam      = family_of(sync_mode, fine_speed);
    assign cfg      = cfg_of(fam);

    always_ff @(posedge clk) begin
        if (rst)            reload_q <= '0;
        else if (reload_we) reload_q <= reload_din;
    end

    bt_prediv #(.RATIO(PRE_DIV)) u_prediv (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .bypass  (cfg.bypass_pre),
        .step    (pre_step)
    );

    bt_reload_counter #(.W(XW)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .load_val  (load_val),
        .step      (pre_step),
        .underflow (base_tick)
    );

    bt_postdiv #(.RATIO(OS_RATIO)) u_postdiv (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .bypass  (cfg.bypass_post),
        .base_in (base_tick),
        .div_out (bit_raw)
    );

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            bit_q <= 1'b0;
            os_q  <= 1'b0;
        end else begin
            bit_q <= bit_raw;
            os_q  <= base_tick && cfg.oversample_on;
        end
    end

    assign bit_tick = bit_q;
    assign os_tick  = os_q;
endmodule

// File: rtl/bitrate_tick_gen_checker.sv
module bitrate_tick_gen_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic sync_mode,
    input logic reload_we,
    input logic bit_tick,
    input logic os_tick
);
    // R3: the shortest bit period is four cycles, so a tick never repeats next cycle
    assert_bit_single_R3: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

    // R5: no oversample strobe in the synchronous family
    assert_sync_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && $past(sync_mode)) |-> !os_tick);

    // R4: each bit tick of an asynchronous family falls on an oversample strobe
    assert_bit_on_os_R4: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && !$past(sync_mode)) |-> os_tick);

    // R6: the cycle after a reload write carries no tick
    assert_write_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        $past(reload_we) |-> (!bit_tick && !os_tick));

    // R7: no ticks in the cycle after an edge with enable low
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> (!bit_tick && !os_tick));

    // R8: ticks stay low during reset
    always_ff @(posedge clk) begin
        if ($past(rst) && rst) begin
            assert_reset_quiet_R8: assert (!bit_tick && !os_tick);
        end
    end
endmodule

bind bitrate_tick_gen bitrate_tick_gen_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .sync_mode (sync_mode),
    .reload_we (reload_we),
    .bit_tick  (bit_tick),
    .os_tick   (os_tick)
);

// File: tb/bitrate_tick_gen_tb.sv
`timescale 1ns/1ps
module bitrate_tick_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       sync_mode = 1'b0;
    logic       fine_speed = 1'b0;
    logic       reload_we = 1'b0;
    logic [7:0] reload_din = 8'd0;
    logic       bit_tick;
    logic       os_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bitrate_tick_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .sync_mode  (sync_mode),
        .fine_speed (fine_speed),
        .reload_we  (reload_we),
        .reload_din (reload_din),
        .bit_tick   (bit_tick),
        .os_tick    (os_tick)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what, input int k);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s cycle %0d: actual %0b expected %0b", req, what, k, act, exp);
        end
    endtask

    // Counts edges after the restart edge; expects bit ticks every per_n, strobes every os_n (0 = none)
    task automatic expect_ticks(input int per_n, input int os_n, input int cycles, input string req);
        for (int k = 1; k <= cycles; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(bit_tick, (k % per_n) == 0, req, "bit_tick", k);
            if (os_n > 0) chk(os_tick, (k % os_n) == 0, "R4", "os_tick", k);
            else          chk(os_tick, 1'b0, "R5", "os_tick", k);
        end
    endtask

    task automatic write_reload(input logic [7:0] x);
        reload_we  = 1'b1;
        reload_din = x;
        @(posedge clk);
        @(negedge clk);
        reload_we  = 1'b0;
        chk(bit_tick, 1'b0, "R6", "bit_tick after write", 0);
        chk(os_tick,  1'b0, "R6", "os_tick after write", 0);
    endtask

    task automatic run_family(input logic s, input logic f, input logic [7:0] x, input int periods, input int extra);
        int n;
        string req;
        sync_mode  = s;
        fine_speed = f;
        if (s)      begin n = 4  * (int'(x) + 1); req = "R3"; end
        else if (f) begin n = 16 * (int'(x) + 1); req = "R2"; end
        else        begin n = 64 * (int'(x) + 1); req = "R1"; end
        write_reload(x);
        expect_ticks(n, s ? 0 : n / 16, n * periods + extra, req);
    endtask

    initial begin
        #(190000 * 10);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: reset state, held with the generator enabled
        sync_mode = 1'b1;
        enable    = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(bit_tick, 1'b0, "R8", "bit_tick in reset", 0);
            chk(os_tick,  1'b0, "R8", "os_tick in reset", 0);
        end
        rst = 1'b0;
        // R8: X is 0 after reset, sync period 4 from the last reset edge
        expect_ticks(4, 0, 20, "R8");

        // R1 / R2 / R3 sweeps over small X
        for (int x = 0; x < 16; x++) run_family(1'b0, 1'b0, 8'(x), 2, 3);
        for (int x = 0; x < 16; x++) run_family(1'b0, 1'b1, 8'(x), 2, 3);
        for (int x = 0; x < 16; x++) run_family(1'b1, 1'b0, 8'(x), 2, 3);
        // R3: fine_speed ignored in sync mode
        for (int x = 0; x < 16; x++) run_family(1'b1, 1'b1, 8'(x), 2, 3);

        // Boundary X = 255 in every family
        run_family(1'b1, 1'b0, 8'd255, 2, 5);
        run_family(1'b0, 1'b1, 8'd255, 2, 5);
        run_family(1'b0, 1'b0, 8'd255, 1, 5);

        // R6: mid-phase writes in each family
        for (int ph = 1; ph < 40; ph += 7) begin
            sync_mode = 1'b0; fine_speed = 1'b0;
            write_reload(8'd6);
            repeat (ph * 11) @(negedge clk);
            write_reload(8'd2);
            expect_ticks(192, 12, 400, "R6");
            fine_speed = 1'b1;
            write_reload(8'd9);
            repeat (ph * 3) @(negedge clk);
            write_reload(8'd9);
            expect_ticks(160, 10, 330, "R6");
            sync_mode = 1'b1;
            write_reload(8'd5);
            repeat (ph) @(negedge clk);
            write_reload(8'd1);
            expect_ticks(8, 0, 20, "R6");
        end

        // R7: disabled generator stays quiet, then restarts from the first enabled edge
        sync_mode = 1'b0; fine_speed = 1'b1;
        write_reload(8'd0);
        repeat (37) @(negedge clk);
        enable = 1'b0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            chk(bit_tick, 1'b0, "R7", "bit_tick disabled", k);
            chk(os_tick,  1'b0, "R7", "os_tick disabled", k);
        end
        enable = 1'b1;
        expect_ticks(16, 1, 50, "R7");
        sync_mode = 1'b0; fine_speed = 1'b0;
        write_reload(8'd1);
        repeat (70) @(negedge clk);
        enable = 1'b0;
        repeat (10) @(negedge clk);
        enable = 1'b1;
        expect_ticks(128, 8, 260, "R7");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule